// File: doc/BRIEF.md
# Dithered LED PWM Generator

This block turns a 16-bit brightness word into a left-aligned LED drive pulse train. A 16-bit phase accumulator advances by a programmable step on every clock, and each wrap of the accumulator starts a new PWM period. The top bits of the accumulator, at the selected resolution of 7 to 10 bits, are compared with the duty value latched for the current period. The output is high while the phase is below that duty value.

Temporal dithering of up to 4 bits makes the average duty finer than one LSB. The low bits of the brightness word form a fraction, and that many periods out of every 2^D get one extra LSB of on-time. A bit-reversed period counter picks these periods so that they are spread evenly. Dithering is active while a brightness ramp is running, or at all times when steady-state dithering is enabled. Every setting is captured only on the first cycle of a period, so a change never cuts or stretches a pulse that has already started.

Top module: `dith_led_pwm`

## Requirements
- R1: `res_sel` values 0, 1, 2 and 3 select 7, 8, 9 and 10 bits of resolution. With `freq_sel` = 4'b1111 the step is 512 >> `res_sel`, so a period lasts exactly 128, 256, 512 or 1024 clocks.
- R2: At 7 bits, `freq_sel` codes 4'b0111 to 4'b1110 use the steps 304, 320, 336, 352, 368, 384, 400 and 448. Each higher resolution halves the step. Over many periods the average period length is 65536/step clocks, so 5 periods at step 320 or step 40 take 1024 or 8192 clocks, 7 periods at step 448 take 1024, and 19 periods at step 304 take 4096.
- R3: `period_start` is high for exactly one cycle, the first cycle of each period. The first period begins on the first clock edge after reset is released.
- R4: In each period the output is high for the first `duty` cycles and low for the rest. The output rises only in a cycle where `period_start` is high.
- R5: With dither depth D and resolution B, `duty` = `brightness` >> D. If `brightness` ≥ 2^(B+D), the output saturates and stays on for the whole period (duty = 2^B).
- R6: With dither active, any 2^D consecutive periods hold exactly F extended pulses, where F = `brightness` mod 2^D. Their total on-time is therefore (`brightness` >> D)·2^D + F clocks.
- R7: The extended periods are spread by bit reversal. With D = 2 and F = 2, every two consecutive periods hold exactly one extended pulse.
- R8: Dithering is active only when `steady_dith_en` or `slope_active` is high. When both are low, the fraction has no effect and each period holds exactly `brightness` >> D on-cycles.
- R9: `dith_sel` values 5 to 7 act as a depth of 4.
- R10: Duty, step and resolution are captured only at a period start. A brightness change in the middle of a period leaves that period's on-time unchanged, and it applies from the next period.
- R11: While `rst_n` is low, `pwm_out` and `period_start` are both low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| brightness | input | 16 | Brightness word, right-aligned to resolution plus dither bits |
| res_sel | input | 2 | Resolution select, 7 + value bits |
| freq_sel | input | 4 | Frequency code that selects the accumulator step |
| dith_sel | input | 3 | Dither depth in bits, 0 to 4, larger values act as 4 |
| steady_dith_en | input | 1 | Enables dithering outside of ramps |
| slope_active | input | 1 | High while a brightness ramp is in progress |
| pwm_out | output | 1 | LED PWM drive |
| period_start | output | 1 | One-cycle pulse on the first cycle of each period |

## Verification
A wrong accumulator step or a wrong resolution shift shows as a wrong gap between `period_start` pulses, visible within one or two periods. A corrupted dither counter, or a wrong reversal, leaves the length of each period unchanged. It shows only as a wrong on-time total across a window of 2^D periods, or as two extended pulses next to each other, so the bench sums whole windows and consecutive pairs. Settings captured outside a period start show up in the very period where the change was made, as a pulse whose on-time matches neither the old value nor the new one.

// File: rtl/pwmdith_pkg.sv
package pwmdith_pkg;

    // 7-bit accumulator steps for each frequency code, index = code
    localparam logic [15:0][15:0] STEP7_DEFAULT = {
        16'd512, 16'd448, 16'd400, 16'd384, 16'd368, 16'd352, 16'd336, 16'd320,
        16'd304, 16'd288, 16'd272, 16'd256, 16'd240, 16'd224, 16'd208, 16'd192
    };

    // reverse the lowest n bits of v, upper bits cleared
    function automatic logic [7:0] rev_low(input logic [7:0] v, input int n);
        logic [7:0] r;
        r = '0;
        for (int i = 0; i < 8; i++) begin
            if (i < n) r[n-1-i] = v[i];
        end
        return r;
    endfunction

endpackage

// File: rtl/pwmdith_step.sv
module pwmdith_step #(
    parameter int ACC_W  = 16,
    parameter int NRES   = 4,
    parameter int FSEL_W = 4,
    parameter logic [2**FSEL_W-1:0][ACC_W-1:0] STEP7_TABLE = pwmdith_pkg::STEP7_DEFAULT,
    localparam int RSEL_W = $clog2(NRES)
) (
    input  logic [FSEL_W-1:0] freq_sel,
    input  logic [RSEL_W-1:0] res_sel,
    output logic [ACC_W-1:0]  step
);
    logic [ACC_W-1:0]            base;
    logic [NRES-1:0][ACC_W-1:0]  cand;

    assign base = STEP7_TABLE[freq_sel];

    // one candidate per resolution, each a halving of the previous
    for (genvar g = 0; g < NRES; g++) begin : g_res
        assign cand[g] = base >> g;
    end

    assign step = cand[res_sel];
endmodule

// File: rtl/pwmdith_duty.sv
module pwmdith_duty #(
    parameter int BRT_W    = 16,
    parameter int RES_MIN  = 7,
    parameter int NRES     = 4,
    parameter int DITH_MAX = 4,
    localparam int RSEL_W  = $clog2(NRES),
    localparam int DSEL_W  = $clog2(DITH_MAX + 1),
    localparam int DUTY_W  = RES_MIN + NRES
) (
    input  logic [BRT_W-1:0]    brightness,
    input  logic [RSEL_W-1:0]   res_sel,
    input  logic [DSEL_W-1:0]   dith_sel,
    input  logic                dith_on,
    input  logic [DITH_MAX-1:0] dcnt,
    output logic [DUTY_W-1:0]   duty
);
    int               dbits;
    int               rbits;
    logic             over;
    logic             extra;
    logic [BRT_W-1:0] coarse;
    logic [BRT_W-1:0] frac;
    logic [BRT_W-1:0] rev;

    always_comb begin
        dbits  = (int'(dith_sel) > DITH_MAX) ? DITH_MAX : int'(dith_sel);
        rbits  = RES_MIN + int'(res_sel);
        over   = (brightness >> (rbits + dbits)) != '0;
        coarse = brightness >> dbits;
        frac   = brightness & ((BRT_W'(1) << dbits) - BRT_W'(1));
        rev    = BRT_W'(pwmdith_pkg::rev_low(8'(dcnt), dbits));
        extra  = dith_on && (rev < frac);
        if (over)
            duty = DUTY_W'(1) << rbits;
        else
            duty = DUTY_W'(coarse) + DUTY_W'(extra);
    end
endmodule

// File: rtl/pwmdith_cmp.sv
module pwmdith_cmp #(
    parameter int ACC_W   = 16,
    parameter int RES_MIN = 7,
    parameter int NRES    = 4,
    localparam int RSEL_W = $clog2(NRES),
    localparam int DUTY_W = RES_MIN + NRES
) (
    input  logic [ACC_W-1:0]  acc,
    input  logic [RSEL_W-1:0] res,
    input  logic [DUTY_W-1:0] duty,
    output logic              on
);
    logic [NRES-1:0][ACC_W-1:0] pos;

    // phase position in LSBs for each selectable resolution
    for (genvar g = 0; g < NRES; g++) begin : g_pos
        assign pos[g] = acc >> (ACC_W - RES_MIN - g);
    end

    assign on = pos[res] < ACC_W'(duty);
endmodule

// File: rtl/dith_led_pwm.sv
module dith_led_pwm #(
    parameter int ACC_W    = 16,
    parameter int BRT_W    = 16,
    parameter int RES_MIN  = 7,
    parameter int NRES     = 4,
    parameter int DITH_MAX = 4,
    parameter int FSEL_W   = 4,
    parameter logic [2**FSEL_W-1:0][ACC_W-1:0] STEP7_TABLE = pwmdith_pkg::STEP7_DEFAULT,
    localparam int RSEL_W  = $clog2(NRES),
    localparam int DSEL_W  = $clog2(DITH_MAX + 1),
    localparam int DUTY_W  = RES_MIN + NRES
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [BRT_W-1:0]  brightness,
    input  logic [RSEL_W-1:0] res_sel,
    input  logic [FSEL_W-1:0] freq_sel,
    input  logic [DSEL_W-1:0] dith_sel,
    input  logic              steady_dith_en,
    input  logic              slope_active,
    output logic              pwm_out,
    output logic              period_start
);
    typedef struct packed {
        logic [ACC_W-1:0]    acc;
        logic [ACC_W-1:0]    step;
        logic [RSEL_W-1:0]   res;
        logic [DUTY_W-1:0]   duty;
        logic [DITH_MAX-1:0] dcnt;
        logic                pwm;
        logic                start;
        logic                init;
    } state_t;

    state_t s_q, s_d;

    logic [ACC_W:0]      sum;
    logic                load;
    logic [ACC_W-1:0]    acc_nx;
    logic [RSEL_W-1:0]   res_nx;
    logic [DUTY_W-1:0]   duty_nx;
    logic [ACC_W-1:0]    step_w;
    logic [DUTY_W-1:0]   duty_w;
    logic                pwm_on;

    pwmdith_step #(
        .ACC_W(ACC_W), .NRES(NRES), .FSEL_W(FSEL_W), .STEP7_TABLE(STEP7_TABLE)
    ) u_step (
        .freq_sel(freq_sel),
        .res_sel (res_sel),
        .step    (step_w)
    );

    pwmdith_duty #(
        .BRT_W(BRT_W), .RES_MIN(RES_MIN), .NRES(NRES), .DITH_MAX(DITH_MAX)
    ) u_duty (
        .brightness(brightness),
        .res_sel   (res_sel),
        .dith_sel  (dith_sel),
        .dith_on   (steady_dith_en | slope_active),
        .dcnt      (s_q.dcnt),
        .duty      (duty_w)
    );

    // phase advance and capture of settings at each wrap
    always_comb begin
        sum     = {1'b0, s_q.acc} + {1'b0, s_q.step};
        load    = s_q.init | sum[ACC_W];
        acc_nx  = s_q.init ? '0 : sum[ACC_W-1:0];
        res_nx  = load ? res_sel : s_q.res;
        duty_nx = load ? duty_w  : s_q.duty;
    end

    pwmdith_cmp #(
        .ACC_W(ACC_W), .RES_MIN(RES_MIN), .NRES(NRES)
    ) u_cmp (
        .acc (acc_nx),
        .res (res_nx),
        .duty(duty_nx),
        .on  (pwm_on)
    );

    always_comb begin
        s_d       = s_q;
        s_d.init  = 1'b0;
        s_d.start = load;
        s_d.acc   = acc_nx;
        s_d.res   = res_nx;
        s_d.duty  = duty_nx;
        s_d.pwm   = pwm_on;
        if (load) begin
            s_d.step = step_w;
            s_d.dcnt = s_q.dcnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q      <= '0;
            s_q.init <= 1'b1;
        end else begin
            s_q <= s_d;
        end
    end

    assign pwm_out      = s_q.pwm;
    assign period_start = s_q.start;
endmodule

// File: rtl/pwmdith_chk.sv
module pwmdith_chk #(
    parameter int ACC_W   = 16,
    parameter int RES_MIN = 7,
    parameter int RSEL_W  = 2,
    parameter int DUTY_W  = 11
) (
    input logic              clk,
    input logic              rst_n,
    input logic              period_start,
    input logic              pwm_out,
    input logic [ACC_W-1:0]  step_q,
    input logic [RSEL_W-1:0] res_q,
    input logic [DUTY_W-1:0] duty_q
);
    // R3
    start_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        period_start |=> !period_start);

    // R4
    rise_at_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pwm_out) |-> period_start);

    // R10
    cfg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !period_start |-> ($stable(duty_q) && $stable(step_q) && $stable(res_q)));

    // R5
    duty_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        duty_q <= (DUTY_W'(1) << (RES_MIN + int'(res_q))));

    // R11
    always @(posedge clk) begin
        if (!rst_n) begin
            reset_quiet_chk: assert (!pwm_out && !period_start);
        end
    end
endmodule

bind dith_led_pwm pwmdith_chk #(
    .ACC_W(ACC_W), .RES_MIN(RES_MIN), .RSEL_W(RSEL_W), .DUTY_W(DUTY_W)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .period_start(period_start),
    .pwm_out     (pwm_out),
    .step_q      (s_q.step),
    .res_q       (s_q.res),
    .duty_q      (s_q.duty)
);

// File: tb/sim_dith_led_pwm.sv
module sim_dith_led_pwm;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] brightness = '0;
    logic [1:0]  res_sel = '0;
    logic [3:0]  freq_sel = 4'hF;
    logic [2:0]  dith_sel = '0;
    logic        steady_dith_en = 1'b0;
    logic        slope_active = 1'b0;
    logic        pwm_out;
    logic        period_start;

    always #(CLK_PERIOD/2) clk = ~clk;

    dith_led_pwm u0 (
        .clk(clk), .rst_n(rst_n), .brightness(brightness), .res_sel(res_sel),
        .freq_sel(freq_sel), .dith_sel(dith_sel), .steady_dith_en(steady_dith_en),
        .slope_active(slope_active), .pwm_out(pwm_out), .period_start(period_start)
    );

    typedef struct {
        bit    skip;
        int    nper;
        int    exp_high;
        int    exp_len;
        string tag;
    } item_t;

    item_t q[$];
    int total = 0, bad = 0;
    int acc_h = 0, acc_l = 0, got = 0, cnt = 0, len = 0;
    bit have = 0, finished = 0;

    task automatic check(bit ok, string tag, int act, int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic push(bit skip, int nper, int h, int l, string tag);
        item_t it;
        it.skip = skip; it.nper = nper; it.exp_high = h; it.exp_len = l; it.tag = tag;
        q.push_back(it);
    endtask

    // monitor: measures each period and pops expected items
    always @(negedge clk) begin
        if (rst_n) begin
            if (period_start) begin
                if (have && q.size() > 0) begin
                    acc_h += cnt; acc_l += len; got++;
                    if (got == q[0].nper) begin
                        if (!q[0].skip) begin
                            check(acc_h == q[0].exp_high, {q[0].tag, " on-time"}, acc_h, q[0].exp_high);
                            if (q[0].exp_len >= 0)
                                check(acc_l == q[0].exp_len, {q[0].tag, " length"}, acc_l, q[0].exp_len);
                        end
                        void'(q.pop_front());
                        acc_h = 0; acc_l = 0; got = 0;
                    end
                end
                have = 1; cnt = int'(pwm_out); len = 1;
            end else if (have) begin
                cnt += int'(pwm_out); len++;
            end
        end
    end

    task automatic sync_start();
        do @(negedge clk); while (!period_start);
        #1;
    endtask

    task automatic drain();
        while (q.size() != 0) @(negedge clk);
    endtask

    // apply new settings mid-period and skip the two periods they may straddle
    task automatic setup(int b, int r, int f, int d, bit st, bit sl);
        sync_start();
        brightness = 16'(b); res_sel = 2'(r); freq_sel = 4'(f); dith_sel = 3'(d);
        steady_dith_en = st; slope_active = sl;
        push(1, 2, 0, 0, "skip");
    endtask

    initial begin
        #(CLK_PERIOD * 180000);
        if (!finished) begin
            total++; bad++;
            $display("FAIL watchdog (all requirements) actual=timeout expected=completion");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        brightness = 16'd64;
        repeat (3) @(negedge clk);
        // R11: quiet outputs in reset
        check(!period_start && !pwm_out, "R11 reset outputs", int'(period_start) + int'(pwm_out), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(period_start == 1'b1, "R3 first start after reset", int'(period_start), 1);
        @(negedge clk);
        check(period_start == 1'b0, "R3 single-cycle strobe", int'(period_start), 0);

        // R1: exact period lengths for code 1111 at each resolution
        for (int r = 0; r < 4; r++) begin
            setup(64, r, 15, 0, 0, 0);
            push(0, 1, 64, 128 << r, "R1 res");
            drain();
        end

        // R4: pulse left-aligned, 64 high cycles at 7 bits
        setup(64, 0, 15, 0, 0, 0);
        drain();
        sync_start();
        check(pwm_out == 1'b1, "R4 high at period start", int'(pwm_out), 1);
        repeat (63) @(negedge clk);
        check(pwm_out == 1'b1, "R4 high at cycle 63", int'(pwm_out), 1);
        @(negedge clk);
        check(pwm_out == 1'b0, "R4 low at cycle 64", int'(pwm_out), 0);

        // R2: fractional periods average to 65536/step
        setup(0, 0, 8, 0, 0, 0);  push(0, 5, 0, 1024, "R2 step320");  drain();
        setup(0, 0, 14, 0, 0, 0); push(0, 7, 0, 1024, "R2 step448");  drain();
        setup(0, 0, 7, 0, 0, 0);  push(0, 19, 0, 4096, "R2 step304"); drain();
        setup(0, 3, 8, 0, 0, 0);  push(0, 5, 0, 8192, "R2 step40");   drain();

        // R5: alignment and saturation
        setup(16'hFFFF, 0, 15, 0, 0, 0); push(0, 1, 128, 128, "R5 full scale"); drain();
        setup(16'h00FF, 0, 15, 1, 0, 0); push(0, 1, 127, 128, "R5 below limit"); drain();
        setup(16'h0100, 0, 15, 1, 0, 0); push(0, 1, 128, 128, "R5 at limit");   drain();
        setup(16'h01FF, 1, 15, 0, 0, 0); push(0, 1, 256, 256, "R5 res8 limit"); drain();

        // R6: dither window totals
        setup((20 << 3) | 1, 0, 15, 3, 1, 0);  push(0, 8, 161, 1024, "R6 d3");  drain();
        setup((33 << 4) | 11, 0, 15, 4, 1, 0); push(0, 16, 539, 2048, "R6 d4"); drain();

        // R7: spread, one extended pulse in every pair
        setup((40 << 2) | 2, 0, 15, 2, 1, 0);
        push(0, 2, 81, 256, "R7 pair a");
        push(0, 1, 40, 128, "R7 shift");
        push(0, 2, 81, 256, "R7 pair b");
        push(0, 2, 81, 256, "R7 pair c");
        drain();

        // R8: gating of the fraction
        setup((20 << 3) | 5, 0, 15, 3, 0, 0); push(0, 8, 160, 1024, "R8 gated off"); drain();
        setup((20 << 3) | 5, 0, 15, 3, 0, 1); push(0, 8, 165, 1024, "R8 slope on");  drain();

        // R9: depth codes above 4 act as 4
        setup((10 << 4) | 3, 0, 15, 6, 1, 0); push(0, 16, 163, 2048, "R9 code6"); drain();

        // R10: mid-period change waits for the next period
        setup(100, 0, 15, 0, 0, 0);
        drain();
        sync_start();
        push(0, 1, 100, 128, "R10 current period");
        repeat (10) @(negedge clk);
        #1;
        brightness = 16'd20;
        push(0, 1, 20, 128, "R10 next period");
        drain();

        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule